// File: doc/BRIEF.md
# Address Region Attribute Matcher

This block classifies a 32-bit physical address against eight programmable memory regions and returns the memory attributes that apply to it. Every region is described by a 24-bit region word and an 8-bit attribute byte, both supplied as flat input vectors. The region word carries a size code in its low nibble and a 4K-aligned base address in its upper 20 bits. The block reports which regions contain the address, together with six merged attributes: cacheable, weak write ordering, weak locking, write gathering, write-through and local-bus suppression.

Regions 0 to 6 start at 4K for code 1, and each higher code doubles the size. The last region starts at 256K for code 1. Code 15 covers the whole 4G space for every region, and code 0 turns the region off. When regions overlap, their attributes are ORed. A single region that disables caching makes the address uncacheable. Bit 0 of the attribute byte has the opposite sense for the last region. A global enable input masks all matching. The result is registered once, so it appears one clock after the address.

Top module: `region_attr_match`

## Requirements
- R1: For regions 0 to 6 with size code c from 1 to 14, the region's hit bit is set when address bits 31:k equal the same bits of the base, where k = 11 + c. The base is taken from region word bits 23:4 as address bits 31:12, and the size code from region word bits 3:0.
- R2: A region whose size code is 0 never hits.
- R3: For region 7 with size code c from 1 to 14, the matching boundary is k = 17 + c. Code 1 gives 256K and code 14 gives 2G.
- R4: Size code 15 makes a region hit every address.
- R5: While enable_i is low, no hit bit is set, every attribute output is 0 and cacheable_o is 1.
- R6: For regions 0 to 6, attribute bit 0 set to 1 makes a hitting address uncacheable.
- R7: For region 7, attribute bit 0 set to 1 leaves the address cacheable, and bit 0 set to 0 makes a hitting address uncacheable.
- R8: Attribute bits 1, 2, 3, 4 and 5 drive weak_order_o, weak_lock_o, write_gather_o, write_thru_o and no_local_o. Each output is the OR of that bit over all hitting regions, and cacheable_o is 0 if any hitting region disables caching.
- R9: An address that hits no region gives all attribute outputs 0 and cacheable_o 1.
- R10: All outputs reflect the inputs sampled at the previous rising clock edge. While rst_ni is low, hit_o is 0, the attribute outputs are 0 and cacheable_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Global matching enable |
| addr_i | input | 32 | Physical address to classify |
| region_i | input | 192 | Eight region words; region n at bits n*24+23:n*24 |
| attr_i | input | 64 | Eight attribute bytes; region n at bits n*8+7:n*8 |
| hit_o | output | 8 | One bit per region containing the address |
| cacheable_o | output | 1 | Address may be cached |
| weak_order_o | output | 1 | Weak write ordering |
| weak_lock_o | output | 1 | Weak locking |
| write_gather_o | output | 1 | Write gathering |
| write_thru_o | output | 1 | Write-through |
| no_local_o | output | 1 | Local-bus signal suppressed |

## Verification
Directed sweeps place one region at a time at the high half of the address space. For every size code, they probe the base, the last byte inside the region, the first byte past it and the byte just below the base. The off-by-one boundaries of the fine regions and of the coarse region show up separately. Attribute-byte patterns are applied to a fine region and to the last region. Used alone and overlapped, they distinguish the inverted cache bit from the normal one and confirm that the remaining bits are ORed. Randomised region sets produce many overlaps, with addresses drawn near the bases, and are compared against a range-based model.

// File: rtl/region_attr_pkg.sv
package region_attr_pkg;
  typedef struct packed {
    logic no_cache;
    logic weak_order;
    logic weak_lock;
    logic write_gather;
    logic write_thru;
    logic no_local;
  } attr_t;

  localparam int ATTR_BITS = 6;
endpackage

// File: rtl/region_decode.sv
module region_decode #(
  parameter int ADDR_W    = 32,
  parameter int BASE_W    = 20,
  parameter int SIZE_W    = 4,
  parameter int SHIFT0    = 11,
  parameter bit CACHE_INV = 1'b0
) (
  input  logic                            enable_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [BASE_W+SIZE_W-1:0]        region_i,
  input  logic [region_attr_pkg::ATTR_BITS-1:0] attr_i,
  output logic                            hit_o,
  output region_attr_pkg::attr_t          attr_o
);
  localparam int LOW_W = ADDR_W - BASE_W;
  localparam logic [SIZE_W-1:0] CODE_FULL = '1;

  logic [SIZE_W-1:0] code;
  logic [ADDR_W-1:0] base_addr;
  logic [ADDR_W-1:0] mask;
  int                shift;

  always_comb begin
    code      = region_i[SIZE_W-1:0];
    base_addr = {region_i[BASE_W+SIZE_W-1:SIZE_W], {LOW_W{1'b0}}};
    shift     = SHIFT0 + int'(code);
    for (int j = 0; j < ADDR_W; j++)
      mask[j] = (j >= shift) && (code != CODE_FULL);
    hit_o = enable_i && (code != '0) && (((addr_i ^ base_addr) & mask) == '0);
  end

  always_comb begin
    attr_o = '0;
    if (hit_o) begin
      attr_o.no_cache     = attr_i[0] ^ CACHE_INV;
      attr_o.weak_order   = attr_i[1];
      attr_o.weak_lock    = attr_i[2];
      attr_o.write_gather = attr_i[3];
      attr_o.write_thru   = attr_i[4];
      attr_o.no_local     = attr_i[5];
    end
  end
endmodule

// File: rtl/attr_merge.sv
module attr_merge #(
  parameter int NUM_REGIONS = 8
) (
  input  region_attr_pkg::attr_t [NUM_REGIONS-1:0] attrs_i,
  output region_attr_pkg::attr_t                   merged_o
);
  always_comb begin
    merged_o = '0;
    for (int i = 0; i < NUM_REGIONS; i++)
      merged_o = merged_o | attrs_i[i];
  end
endmodule

// File: rtl/region_attr_match.sv
module region_attr_match #(
  parameter int NUM_REGIONS  = 8,
  parameter int ADDR_W       = 32,
  parameter int BASE_W       = 20,
  parameter int SIZE_W       = 4,
  parameter int FINE_SHIFT   = 11,
  parameter int COARSE_SHIFT = 17,
  parameter bit REG_OUT      = 1'b1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          enable_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [NUM_REGIONS*24-1:0]     region_i,
  input  logic [NUM_REGIONS*8-1:0]      attr_i,
  output logic [NUM_REGIONS-1:0]        hit_o,
  output logic                          cacheable_o,
  output logic                          weak_order_o,
  output logic                          weak_lock_o,
  output logic                          write_gather_o,
  output logic                          write_thru_o,
  output logic                          no_local_o
);
  import region_attr_pkg::*;

  localparam int RW = BASE_W + SIZE_W;
  localparam int AW = 8;

  logic [NUM_REGIONS-1:0] hit_d;
  attr_t [NUM_REGIONS-1:0] attr_d;
  attr_t merged_d, merged_q;
  logic [NUM_REGIONS-1:0] hit_q;
  logic [AW-1:0] attr_unused;

  assign attr_unused = '0;

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
    localparam bit LAST = (i == NUM_REGIONS - 1);
    region_decode #(
      .ADDR_W   (ADDR_W),
      .BASE_W   (BASE_W),
      .SIZE_W   (SIZE_W),
      .SHIFT0   (LAST ? COARSE_SHIFT : FINE_SHIFT),
      .CACHE_INV(LAST)
    ) u_dec (
      .enable_i(enable_i),
      .addr_i  (addr_i),
      .region_i(region_i[i*RW +: RW]),
      .attr_i  (attr_i[i*AW +: ATTR_BITS] | attr_unused[ATTR_BITS-1:0]),
      .hit_o   (hit_d[i]),
      .attr_o  (attr_d[i])
    );
  end

  attr_merge #(.NUM_REGIONS(NUM_REGIONS)) u_merge (
    .attrs_i (attr_d),
    .merged_o(merged_d)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hit_q    <= '0;
        merged_q <= '0;
      end else begin
        hit_q    <= hit_d;
        merged_q <= merged_d;
      end
    end
  end else begin : g_comb
    assign hit_q    = hit_d;
    assign merged_q = merged_d;
  end

  assign hit_o          = hit_q;
  assign cacheable_o    = ~merged_q.no_cache;
  assign weak_order_o   = merged_q.weak_order;
  assign weak_lock_o    = merged_q.weak_lock;
  assign write_gather_o = merged_q.write_gather;
  assign write_thru_o   = merged_q.write_thru;
  assign no_local_o     = merged_q.no_local;
endmodule

// File: rtl/region_attr_match_chk.sv
module region_attr_match_chk #(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32,
  parameter int BASE_W      = 20,
  parameter int SIZE_W      = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      enable_i,
  input logic [ADDR_W-1:0]         addr_i,
  input logic [NUM_REGIONS*24-1:0] region_i,
  input logic [NUM_REGIONS-1:0]    hit_o,
  input logic                      cacheable_o,
  input logic                      weak_order_o,
  input logic                      weak_lock_o,
  input logic                      write_gather_o,
  input logic                      write_thru_o,
  input logic                      no_local_o
);
  localparam int RW = BASE_W + SIZE_W;
  localparam int LOW_W = ADDR_W - BASE_W;

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;

  AST_OFF_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !$past(enable_i) |-> hit_o == '0); // R5

  AST_IDLE_ATTRS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o == '0 |-> cacheable_o && !weak_order_o && !weak_lock_o &&
                    !write_gather_o && !write_thru_o && !no_local_o); // R9

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_chk
    AST_CODE0_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && $past(region_i[i*RW +: SIZE_W]) == '0 |-> !hit_o[i]); // R2

    AST_FULL_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && $past(enable_i) && $past(region_i[i*RW +: SIZE_W]) == '1
      |-> hit_o[i]); // R4

    AST_BASE_PAGE_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && $past(enable_i) && $past(region_i[i*RW +: SIZE_W]) != '0 &&
      $past(addr_i[ADDR_W-1:LOW_W]) == $past(region_i[i*RW+SIZE_W +: BASE_W])
      |-> hit_o[i]); // R1
  end
endmodule

bind region_attr_match region_attr_match_chk #(
  .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .BASE_W(BASE_W), .SIZE_W(SIZE_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .addr_i(addr_i),
  .region_i(region_i), .hit_o(hit_o), .cacheable_o(cacheable_o),
  .weak_order_o(weak_order_o), .weak_lock_o(weak_lock_o),
  .write_gather_o(write_gather_o), .write_thru_o(write_thru_o),
  .no_local_o(no_local_o)
);

// File: tb/region_attr_match_test.sv
module region_attr_match_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [31:0] addr = '0;
  logic [191:0] region = '0;
  logic [63:0] attr = '0;
  logic [7:0] hit;
  logic cach, wwo, wlk, wgt, wth, nlb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  region_attr_match uut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .addr_i(addr),
    .region_i(region), .attr_i(attr), .hit_o(hit), .cacheable_o(cach),
    .weak_order_o(wwo), .weak_lock_o(wlk), .write_gather_o(wgt),
    .write_thru_o(wth), .no_local_o(nlb)
  );

  // {hit[7:0], cacheable, wwo, wlock, wgather, wthru, nolocal}
  function automatic logic [13:0] model(logic [31:0] a, logic e,
                                        logic [191:0] rg, logic [63:0] at);
    logic [7:0] h = '0;
    logic nc = 1'b0;
    logic [4:0] o = '0;
    for (int i = 0; i < 8; i++) begin
      logic [3:0] c = rg[i*24 +: 4];
      logic [63:0] b, sz;
      bit in = 1'b0;
      if (e && c != 0) begin
        if (c == 4'hF) in = 1'b1;
        else begin
          sz = 64'd1 << ((i == 7 ? 17 : 11) + int'(c));
          b  = {32'd0, rg[i*24+4 +: 20], 12'd0} & ~(sz - 64'd1);
          in = ({32'd0, a} >= b) && ({32'd0, a} < b + sz);
        end
      end
      if (in) begin
        h[i] = 1'b1;
        nc |= (i == 7) ? ~at[i*8] : at[i*8];
        o  |= {at[i*8+1], at[i*8+2], at[i*8+3], at[i*8+4], at[i*8+5]};
      end
    end
    return {h, ~nc, o};
  endfunction

  task automatic check(string tag, logic [13:0] exp);
    logic [13:0] act = {hit, cach, wwo, wlk, wgt, wth, nlb};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, addr, act, exp);
    end
  endtask

  task automatic apply(string tag, logic [31:0] a);
    logic [13:0] exp;
    @(negedge clk);
    addr = a;
    exp = model(a, en, region, attr);
    @(negedge clk);
    check(tag, exp);
  endtask

  task automatic sweep(int r, logic [3:0] c, string tag);
    logic [31:0] base = 32'h8000_0000;
    logic [31:0] sz;
    region = '0;
    region[r*24 +: 24] = {base[31:12], c};
    attr = '0;
    attr[r*8 +: 8] = 8'($urandom);
    sz = (c == 4'hF) ? 32'h0 : 32'd1 << ((r == 7 ? 17 : 11) + int'(c));
    apply(tag, base);
    apply(tag, base + sz - 32'd1);
    apply(tag, base + sz);
    apply(tag, base - 32'd1);
  endtask

  initial begin
    for (int n = 0; n < 100000 && !done; n++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    en = 1'b1;
    region[23:0] = 24'h00001F;
    addr = 32'h1234_5678;
    repeat (3) @(negedge clk);
    check("R10 reset", {8'h00, 1'b1, 5'h00});
    rst_n = 1'b1;

    // R1 fine sizes, R3 coarse sizes, R4 full
    for (int c = 1; c < 15; c++) begin
      sweep(0, 4'(c), "R1");
      sweep(3, 4'(c), "R1");
      sweep(7, 4'(c), "R3");
    end
    sweep(2, 4'hF, "R4");
    sweep(7, 4'hF, "R4");

    // R2 code zero
    region = '0;
    region[5*24 +: 24] = 24'h800000;
    attr = '1;
    apply("R2", 32'h8000_0000);

    // R6 fine no-cache bit, R7 inverted bit on last region
    region = '0;
    region[1*24 +: 24] = 24'h400001;
    region[7*24 +: 24] = 24'h400001;
    attr = '0;
    attr[1*8 +: 8] = 8'h01;
    attr[7*8 +: 8] = 8'h01;
    apply("R6", 32'h4000_0010);
    attr[1*8 +: 8] = 8'h00;
    apply("R7", 32'h4000_0010);
    attr[7*8 +: 8] = 8'h00;
    apply("R7", 32'h4000_2000);
    apply("R9", 32'h3FFF_FFFF);

    // R8 overlap and bit mapping
    attr[1*8 +: 8] = 8'h0A;
    attr[7*8 +: 8] = 8'h31;
    apply("R8", 32'h4000_0fff);
    attr[1*8 +: 8] = 8'h04;
    attr[7*8 +: 8] = 8'h01;
    apply("R8", 32'h4000_0000);

    // R5 global enable
    en = 1'b0;
    region[2*24 +: 24] = 24'h00000F;
    attr = '1;
    apply("R5", 32'h4000_0000);
    en = 1'b1;

    // R8 random overlaps
    for (int t = 0; t < 400; t++) begin
      int j = $urandom_range(0, 7);
      logic [31:0] a;
      for (int i = 0; i < 8; i++) begin
        region[i*24 +: 24] = {20'($urandom), 4'($urandom_range(0, 15))};
        if ($urandom_range(0, 1) == 1) region[i*24+4 +: 20] = region[j*24+4 +: 20];
      end
      attr = {$urandom, $urandom};
      en = ($urandom_range(0, 9) != 0);
      a = {region[j*24+4 +: 20], 12'd0} ^ ($urandom & ((32'd1 << $urandom_range(0, 31)) - 32'd1));
      apply("R8", a);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule